// File: doc/BRIEF.md
# BCD Calendar Clock in a Byte-Wide RAM

This block pairs a byte-wide static RAM with a calendar clock. The eight locations at the top of the address space belong to the clock. Seven of them hold the current time and date in packed BCD. The eighth is a control byte. The clock bytes are ordinary storage cells. Internal calendar counters run from a one-pulse-per-second tick. After each tick, a refresh engine copies the counters into the clock bytes as soon as the host is not using the bus.

The host reaches every location through an active-low chip enable, output enable and write enable. These are sampled on the system clock. Two control bits manage the time bytes:
- The read latch freezes the bytes so the host sees a snapshot that cannot change halfway through a read.
- The write latch opens the bytes to host writes. When the write latch is cleared, the counters take their new value from the bytes.

While the power-fail input is high, the interface acts as deselected and drops every write, but counting goes on.

Top module: `rtcram_top`

## Requirements
- R1: After reset, `dout_oe` is low. The clock bytes read year 00 (addr 1FFFFh), month 01 (1FFFEh), date 01 (1FFFDh), weekday 1 (1FFFCh), hour 00 (1FFFBh), minute 00 (1FFFAh) and second 00 (1FFF9h). The control byte (1FFF8h) reads 00h.
- R2: `dout_oe` is high only when `ce_n`=0, `we_n`=1 and `oe_n`=0, and `pwr_fail`=0. A cycle with `ce_n`=0 and `we_n`=0 is a write whatever the level of `oe_n`.
- R3: Writes and reads below 1FFF8h reach the RAM array, which is indexed by the low `MEM_AW` address bits.
- R4: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the date. All values are packed BCD.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R6: February ends on the 29th when the BCD year is a multiple of four, and on the 28th otherwise.
- R7: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00. The weekday counts 1 to 7 and returns to 1 at each new date.
- R8: A tick advances the counters at the clock edge that samples it. The clock bytes show the new time one edge later when the bus is idle. There is exactly one advance per tick.
- R9: While control bit 7 is 1, the clock bytes do not change but counting continues. After the bit is cleared, the next refresh shows the full count.
- R10: Host writes to 1FFF9h to 1FFFFh are taken only while control bit 6 is 1. Otherwise they are ignored. A control write that clears bit 6 loads the counters from the clock bytes.
- R11: Control bits 5:0 are stored and read back unchanged, and they have no effect on counting.
- R12: A host access (`ce_n`=0 without power fail) in a cycle where a refresh is due wins the cycle. The refresh happens at the first later cycle without a host access.
- R13: While `pwr_fail`=1, writes to the RAM, the clock bytes and the control byte are ignored, `dout_oe` stays low, and ticks still advance the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_fail | input | 1 | Supply out of tolerance; blocks the host |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_oe | output | 1 | Read data valid; low means high impedance |

## Verification
The bench loads dates just before 30-day and 31-day month ends, before a February 28th in a non-leap year and in a leap year, and before the year 99 end. It then ticks once and reads every byte. A wrong month table or leap test shows up as a date of 31, 29 or 00 where 01 is due. A read placed in the cycle just after a tick must still return the old second. A design that lets the refresh beat the host would show the new value there, or would lose the refresh for good. Under the read latch and under power fail, the ticks must be counted without being shown. A block that stops counting, or one that still accepts writes, returns a stale second or corrupted RAM once the condition ends.

// File: rtl/rtcram_pkg.sv
package rtcram_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mo;
        logic [7:0] dt;
        logic [7:0] dw;
        logic [7:0] hr;
        logic [7:0] mi;
        logic [7:0] se;
    } cal_t;

    typedef enum logic [2:0] {
        SLOT_CTRL = 3'd0,
        SLOT_SEC  = 3'd1,
        SLOT_MIN  = 3'd2,
        SLOT_HR   = 3'd3,
        SLOT_DOW  = 3'd4,
        SLOT_DATE = 3'd5,
        SLOT_MON  = 3'd6,
        SLOT_YR   = 3'd7
    } slot_e;

    localparam int CTRL_RD_LATCH = 7;
    localparam int CTRL_WR_LATCH = 6;

    localparam cal_t CAL_RESET = '{yr: 8'h00, mo: 8'h01, dt: 8'h01, dw: 8'h01,
                                   hr: 8'h00, mi: 8'h00, se: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Last date of a month, returned in BCD; leap rule on the two-digit year
    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = bcd_to_bin(yr);
        case (mo)
            8'h02:                     return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] slot_get(input cal_t c, input slot_e s);
        case (s)
            SLOT_SEC:  return c.se;
            SLOT_MIN:  return c.mi;
            SLOT_HR:   return c.hr;
            SLOT_DOW:  return c.dw;
            SLOT_DATE: return c.dt;
            SLOT_MON:  return c.mo;
            SLOT_YR:   return c.yr;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic cal_t slot_put(input cal_t c, input slot_e s, input logic [7:0] v);
        cal_t r;
        r = c;
        case (s)
            SLOT_SEC:  r.se = v;
            SLOT_MIN:  r.mi = v;
            SLOT_HR:   r.hr = v;
            SLOT_DOW:  r.dw = v;
            SLOT_DATE: r.dt = v;
            SLOT_MON:  r.mo = v;
            SLOT_YR:   r.yr = v;
            default:   r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtcram_calendar.sv
module rtcram_calendar
    import rtcram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t cal_now
);

    cal_t nxt;
    logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

    always_comb begin
        nxt      = cal_now;
        sec_wrap = (cal_now.se == 8'h59);
        min_wrap = sec_wrap && (cal_now.mi == 8'h59);
        hr_wrap  = min_wrap && (cal_now.hr == 8'h23);
        day_wrap = hr_wrap && (cal_now.dt == month_last(cal_now.mo, cal_now.yr));
        mon_wrap = day_wrap && (cal_now.mo == 8'h12);

        nxt.se = sec_wrap ? 8'h00 : bcd_inc(cal_now.se);
        if (sec_wrap)
            nxt.mi = (cal_now.mi == 8'h59) ? 8'h00 : bcd_inc(cal_now.mi);
        if (min_wrap)
            nxt.hr = (cal_now.hr == 8'h23) ? 8'h00 : bcd_inc(cal_now.hr);
        if (hr_wrap) begin
            nxt.dw = (cal_now.dw == 8'h07) ? 8'h01 : cal_now.dw + 8'h01;
            nxt.dt = day_wrap ? 8'h01 : bcd_inc(cal_now.dt);
        end
        if (day_wrap)
            nxt.mo = mon_wrap ? 8'h01 : bcd_inc(cal_now.mo);
        if (mon_wrap)
            nxt.yr = (cal_now.yr == 8'h99) ? 8'h00 : bcd_inc(cal_now.yr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cal_now <= CAL_RESET;
        else if (load)
            cal_now <= load_val;
        else if (tick)
            cal_now <= nxt;
    end

endmodule

// File: rtl/rtcram_regfile.sv
module rtcram_regfile
    import rtcram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_act,
    input  logic       wr_en,
    input  logic       in_clk_region,
    input  slot_e      slot,
    input  logic [7:0] wdata,
    input  logic       tick,
    input  cal_t       cal_now,
    output cal_t       bytes_q,
    output logic [7:0] ctrl_q,
    output logic       pending,
    output logic       load_now
);

    logic wr_ctrl, wr_time, refresh_go;

    assign wr_ctrl    = wr_en && in_clk_region && (slot == SLOT_CTRL);
    assign wr_time    = wr_en && in_clk_region && (slot != SLOT_CTRL) && ctrl_q[CTRL_WR_LATCH];
    assign load_now   = wr_ctrl && ctrl_q[CTRL_WR_LATCH] && !wdata[CTRL_WR_LATCH];
    assign refresh_go = pending && !host_act && !ctrl_q[CTRL_RD_LATCH] && !ctrl_q[CTRL_WR_LATCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= CAL_RESET;
            ctrl_q  <= 8'h00;
            pending <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= wdata;
            if (wr_time)
                bytes_q <= slot_put(bytes_q, slot, wdata);
            else if (refresh_go)
                bytes_q <= cal_now;
            if (tick && !load_now)
                pending <= 1'b1;
            else if (refresh_go)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/rtcram_array.sv
module rtcram_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/rtcram_top.sv
module rtcram_top
    import rtcram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              pwr_fail,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe
);

    localparam int SLOT_W = 3;

    logic       host_act, host_wr, host_rd, in_clk_region, ram_we, load_now, pending;
    slot_e      slot;
    cal_t       cal_now, bytes_q;
    logic [7:0] ctrl_q, ram_rdata, reg_rdata;

    assign host_act      = !ce_n && !pwr_fail;
    assign host_wr       = host_act && !we_n;
    assign host_rd       = host_act && we_n && !oe_n;
    assign in_clk_region = &addr[ADDR_W-1:SLOT_W];
    assign slot          = slot_e'(addr[SLOT_W-1:0]);
    assign ram_we        = host_wr && !in_clk_region;

    rtcram_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load     (load_now),
        .load_val (bytes_q),
        .cal_now  (cal_now)
    );

    rtcram_regfile u_regs (
        .clk           (clk),
        .rst           (rst),
        .host_act      (host_act),
        .wr_en         (host_wr),
        .in_clk_region (in_clk_region),
        .slot          (slot),
        .wdata         (din),
        .tick          (tick_1hz),
        .cal_now       (cal_now),
        .bytes_q       (bytes_q),
        .ctrl_q        (ctrl_q),
        .pending       (pending),
        .load_now      (load_now)
    );

    rtcram_array #(.AW(MEM_AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (addr[MEM_AW-1:0]),
        .wdata (din),
        .rdata (ram_rdata)
    );

    assign reg_rdata = (slot == SLOT_CTRL) ? ctrl_q : slot_get(bytes_q, slot);
    assign dout_oe   = host_rd;
    assign dout      = !host_rd ? 8'h00 : (in_clk_region ? reg_rdata : ram_rdata);

endmodule

// File: rtl/rtcram_checker.sv
module rtcram_checker
    import rtcram_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       pwr_fail,
    input logic       tick,
    input logic       dout_oe,
    input logic       host_act,
    input logic       pending,
    input logic       load_now,
    input logic [7:0] ctrl_q,
    input cal_t       bytes_q,
    input cal_t       cal_now
);

    p_idle_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || pwr_fail) |-> !dout_oe);

    p_pfail_ctrl_r13: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> $stable(ctrl_q));

    p_sec_bcd_r4: assert property (@(posedge clk) disable iff (rst)
        (cal_now.se[3:0] <= 4'd9) && (cal_now.se < 8'h60));

    p_date_range_r5: assert property (@(posedge clk) disable iff (rst)
        (cal_now.dt != 8'h00) && (cal_now.dt <= month_last(cal_now.mo, cal_now.yr)));

    p_weekday_r7: assert property (@(posedge clk) disable iff (rst)
        (cal_now.dw >= 8'h01) && (cal_now.dw <= 8'h07));

    p_tick_pending_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_now) |=> pending);

    p_rd_latch_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CTRL_RD_LATCH] && !ctrl_q[CTRL_WR_LATCH]) |=> $stable(bytes_q));

    p_host_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (host_act && pending) |=> pending);

endmodule

bind rtcram_top rtcram_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .pwr_fail (pwr_fail),
    .tick     (tick_1hz),
    .dout_oe  (dout_oe),
    .host_act (host_act),
    .pending  (pending),
    .load_now (load_now),
    .ctrl_q   (ctrl_q),
    .bytes_q  (bytes_q),
    .cal_now  (cal_now)
);

// File: tb/sim_rtcram_top.sv
module sim_rtcram_top;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe;

    int    checks = 0, errors = 0;
    bit    running = 0;
    string tag = "R1";

    // reference model state (binary counters, BCD byte images)
    int m_yr, m_mo, m_dt, m_dw, m_hr, m_mi, m_se;
    int m_bytes [8];
    int m_ctrl;
    bit m_pend;
    int ram [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcram_top u0 (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    function automatic int tobcd(int v); return (v / 10) * 16 + (v % 10); endfunction
    function automatic int frombcd(int v); return (v / 16) * 10 + (v % 16); endfunction
    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit act, wr, clkreg, refresh, ld;
        int s, oc;
        if (rst) begin
            m_yr = 0; m_mo = 1; m_dt = 1; m_dw = 1; m_hr = 0; m_mi = 0; m_se = 0;
            m_bytes = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
            m_ctrl = 0; m_pend = 0;
        end else begin
            act = !ce_n && !pwr_fail;
            wr = act && !we_n;
            clkreg = (addr >= 17'h1FFF8);
            s = int'(addr) % 8;
            oc = m_ctrl;
            ld = 0;
            refresh = m_pend && !act && !oc[7] && !oc[6];
            if (wr) begin
                if (clkreg) begin
                    if (s == 0) begin
                        m_ctrl = int'(din);
                        if (oc[6] && !din[6]) ld = 1;
                    end else if (oc[6]) m_bytes[s] = int'(din);
                end else ram[int'(addr) % RAM_WORDS] = int'(din);
            end
            if (refresh) begin
                m_bytes[1] = tobcd(m_se); m_bytes[2] = tobcd(m_mi); m_bytes[3] = tobcd(m_hr);
                m_bytes[4] = m_dw; m_bytes[5] = tobcd(m_dt); m_bytes[6] = tobcd(m_mo);
                m_bytes[7] = tobcd(m_yr);
                m_pend = 0;
            end
            if (ld) begin
                m_se = frombcd(m_bytes[1]); m_mi = frombcd(m_bytes[2]); m_hr = frombcd(m_bytes[3]);
                m_dw = m_bytes[4]; m_dt = frombcd(m_bytes[5]); m_mo = frombcd(m_bytes[6]);
                m_yr = frombcd(m_bytes[7]);
            end else if (tick_1hz) begin
                m_pend = 1;
                m_se++;
                if (m_se == 60) begin
                    m_se = 0; m_mi++;
                    if (m_mi == 60) begin
                        m_mi = 0; m_hr++;
                        if (m_hr == 24) begin
                            m_hr = 0; m_dw = m_dw % 7 + 1; m_dt++;
                            if (m_dt > mdays(m_mo, m_yr)) begin
                                m_dt = 1; m_mo++;
                                if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
                            end
                        end
                    end
                end
            end
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        bit exp_oe;
        int s, ev;
        if (running && !rst) begin
            exp_oe = !ce_n && we_n && !oe_n && !pwr_fail;
            chk(dout_oe === exp_oe, pwr_fail ? "R13" : "R2", int'(dout_oe), int'(exp_oe));
            if (exp_oe) begin
                s = int'(addr) % 8;
                if (addr >= 17'h1FFF8) begin
                    ev = (s == 0) ? m_ctrl : m_bytes[s];
                    chk(dout === ev[7:0], tag, int'(dout), ev);
                end else if (ram.exists(int'(addr) % RAM_WORDS)) begin
                    ev = ram[int'(addr) % RAM_WORDS];
                    chk(dout === ev[7:0], tag, int'(dout), ev);
                end
            end
        end
    end

    task automatic drive(bit ce, bit we, bit oe, logic [16:0] a, logic [7:0] d, bit tk);
        @(negedge clk); #1;
        ce_n = ce; we_n = we; oe_n = oe; addr = a; din = d; tick_1hz = tk;
    endtask

    task automatic idle(int n);
        repeat (n) drive(1, 1, 1, addr, din, 0);
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d);
        drive(0, 0, 0, a, d, 0);   // oe_n low during write: must be ignored (R2)
    endtask

    task automatic expect_rd(logic [16:0] a, logic [7:0] v, string req);
        drive(0, 1, 0, a, 8'h00, 0);
        @(negedge clk);
        chk(dout_oe === 1'b1 && dout === v, req, int'(dout), int'(v));
    endtask

    task automatic capture(logic [16:0] a, output logic [7:0] v);
        drive(0, 1, 0, a, 8'h00, 0);
        @(negedge clk);
        v = dout;
    endtask

    task automatic do_tick();
        drive(1, 1, 1, addr, din, 1);
        idle(2);
    endtask

    task automatic set_time(logic [7:0] yr, mo, dt, dw, hr, mi, se);
        wr(17'h1FFF8, 8'h40);
        wr(17'h1FFFF, yr); wr(17'h1FFFE, mo); wr(17'h1FFFD, dt); wr(17'h1FFFC, dw);
        wr(17'h1FFFB, hr); wr(17'h1FFFA, mi); wr(17'h1FFF9, se);
        wr(17'h1FFF8, 8'h00);      // clearing the write latch loads the counters (R10)
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] snap, snap2;
        running = 1;
        repeat (3) begin
            @(negedge clk);
            chk(dout_oe === 1'b0, "R1", int'(dout_oe), 0);
        end
        #1 rst = 0;
        idle(1);

        tag = "R1";
        expect_rd(17'h1FFFF, 8'h00, "R1"); expect_rd(17'h1FFFE, 8'h01, "R1");
        expect_rd(17'h1FFFD, 8'h01, "R1"); expect_rd(17'h1FFFC, 8'h01, "R1");
        expect_rd(17'h1FFFB, 8'h00, "R1"); expect_rd(17'h1FFFA, 8'h00, "R1");
        expect_rd(17'h1FFF9, 8'h00, "R1"); expect_rd(17'h1FFF8, 8'h00, "R1");

        tag = "R3";
        wr(17'h00010, 8'hA5); wr(17'h1FFF7, 8'h3C); wr(17'h003F0, 8'h5A);
        idle(1);
        expect_rd(17'h00010, 8'hA5, "R3"); expect_rd(17'h1FFF7, 8'h3C, "R3");
        expect_rd(17'h003F0, 8'h5A, "R3");
        drive(0, 1, 1, 17'h00010, 8'h00, 0);      // ce low, oe high: outputs off (R2)
        @(negedge clk);
        chk(dout_oe === 1'b0, "R2", int'(dout_oe), 0);

        tag = "R4";
        set_time(8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h58);
        expect_rd(17'h1FFF9, 8'h58, "R10");
        do_tick();
        expect_rd(17'h1FFF9, 8'h59, "R4");
        do_tick();
        expect_rd(17'h1FFF9, 8'h00, "R4"); expect_rd(17'h1FFFA, 8'h00, "R4");
        expect_rd(17'h1FFFB, 8'h00, "R4");
        expect_rd(17'h1FFFD, 8'h01, "R5"); expect_rd(17'h1FFFE, 8'h05, "R5");
        expect_rd(17'h1FFFC, 8'h04, "R7");

        tag = "R5";
        set_time(8'h23, 8'h01, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFD, 8'h01, "R5"); expect_rd(17'h1FFFE, 8'h02, "R5");
        expect_rd(17'h1FFFC, 8'h01, "R7");
        set_time(8'h23, 8'h06, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFD, 8'h01, "R5"); expect_rd(17'h1FFFE, 8'h07, "R5");

        tag = "R6";
        set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFD, 8'h01, "R6"); expect_rd(17'h1FFFE, 8'h03, "R6");
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFD, 8'h29, "R6"); expect_rd(17'h1FFFE, 8'h02, "R6");
        set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFD, 8'h01, "R6"); expect_rd(17'h1FFFE, 8'h03, "R6");

        tag = "R7";
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        do_tick();
        expect_rd(17'h1FFFF, 8'h00, "R7"); expect_rd(17'h1FFFE, 8'h01, "R7");
        expect_rd(17'h1FFFD, 8'h01, "R7"); expect_rd(17'h1FFFC, 8'h06, "R7");

        tag = "R12";
        drive(1, 1, 1, addr, din, 1);
        expect_rd(17'h1FFF9, 8'h00, "R12");     // refresh deferred by the read
        idle(1);
        expect_rd(17'h1FFF9, 8'h01, "R12");

        tag = "R8";
        do_tick();
        expect_rd(17'h1FFF9, 8'h02, "R8");
        idle(20);
        expect_rd(17'h1FFF9, 8'h02, "R8");

        tag = "R9";
        wr(17'h1FFF8, 8'h80);
        capture(17'h1FFF9, snap);
        do_tick(); do_tick(); do_tick();
        expect_rd(17'h1FFF9, snap, "R9");
        wr(17'h1FFF8, 8'h00);
        idle(2);
        expect_rd(17'h1FFF9, 8'(tobcd(frombcd(int'(snap)) + 3)), "R9");

        tag = "R10";
        capture(17'h1FFF9, snap);
        wr(17'h1FFF9, 8'h33);
        idle(1);
        expect_rd(17'h1FFF9, snap, "R10");

        tag = "R11";
        wr(17'h1FFF8, 8'h15);
        idle(1);
        expect_rd(17'h1FFF8, 8'h15, "R11");
        capture(17'h1FFF9, snap);
        do_tick();
        expect_rd(17'h1FFF9, 8'(tobcd(frombcd(int'(snap)) + 1)), "R11");

        tag = "R13";
        pwr_fail = 1;
        wr(17'h1FFF8, 8'h80); wr(17'h00010, 8'hFF);
        drive(0, 1, 0, 17'h00010, 8'h00, 0);
        @(negedge clk);
        chk(dout_oe === 1'b0, "R13", int'(dout_oe), 0);
        do_tick(); do_tick();
        @(negedge clk); #1 pwr_fail = 0;
        idle(2);
        expect_rd(17'h00010, 8'hA5, "R13");
        expect_rd(17'h1FFF8, 8'h15, "R13");
        expect_rd(17'h1FFF9, 8'(tobcd(frombcd(int'(snap)) + 3)), "R13");
        capture(17'h1FFF9, snap2);
        idle(2);

        running = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule